// File: doc/BRIEF.md
# Power-Management Control Register with Core Halt

This block is the power-management control register of a small 32-bit processor core. It sits on the core's special-purpose register (SPR) port and answers at a single SPR index, built from a group number and a register number as `(group << 11) + number`. By default that is group 8, number 0, which gives index 0x4000. Software reads and writes the whole register through this port. The low byte holds the control fields: a slow-down factor, a doze request, a sleep request, a clock-gating enable and a suspend enable. The block also sets one bit in the core's unit-presence vector, so that software can find out the register exists.

A write that leaves the doze bit or the sleep bit set puts the core into a halted state from the next clock. The block also records the address of the instruction after the writing one, so the core can resume there. While the core is halted, a pending unmasked interrupt or a tick-timer event (the timer firing or being reprogrammed) releases the halt on the next clock. When the core enters an exception, both the doze bit and the sleep bit are cleared and any halt ends. The slow-down, clock-gating and suspend fields are only stored and driven out. This block does no clock gating, voltage control or clock division itself.

Top module: `pwr_ctl_spr`

## Requirements
- R1: After reset the stored register is 0, `halt` is 0 and a read at the register's index returns 0.
- R2: Only SPR index `(8 << 11) + 0` = 0x4000 selects the register. A write at any other index changes neither the stored value nor `halt`, and a read at any other index returns 0.
- R3: A read at the register's index returns the full 32-bit value last written, including the bits above bit 7.
- R4: A write at the register's index whose data has bit 4 (doze) or bit 5 (sleep) set drives `halt` to 1 from the next clock edge.
- R5: On a halting write, `resume_pc` takes the value `insn_pc + 4`, wrapping modulo 2^32. Any write that does not halt leaves `resume_pc` unchanged.
- R6: A write with bits 4 and 5 both clear stores the data and does not assert `halt`.
- R7: When `exc_entry` is high at a clock edge, bits 4 and 5 of the stored value become 0, the other bits stay, and `halt` becomes 0. If a write comes in the same cycle, the written value is stored with bits 4 and 5 cleared and no halt occurs.
- R8: While `halt` is 1, `irq_pend` or `tick_evt` high at a clock edge clears `halt` at that edge. With neither of them and no exception, `halt` stays at 1.
- R9: `unit_present` has exactly one bit set, the bit at index `PRES_BIT` (default 9).
- R10: `slow_div` is bits 3:0 of the stored value, `clkgate_en` is bit 6 and `suspend_en` is bit 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spr_addr | input | 16 | SPR index of the current access |
| spr_wr | input | 1 | Write strobe for the SPR access |
| spr_wdata | input | 32 | Write data |
| spr_rdata | output | 32 | Read data (0 when the index does not match) |
| insn_pc | input | 32 | Address of the instruction performing the access |
| exc_entry | input | 1 | Core is entering an exception or interrupt |
| irq_pend | input | 1 | An unmasked interrupt is pending |
| tick_evt | input | 1 | Tick timer fired or was reprogrammed |
| halt | output | 1 | Core must issue no instructions |
| resume_pc | output | 32 | Address at which execution resumes after the halt |
| slow_div | output | 4 | Slow-down factor field |
| clkgate_en | output | 1 | Dynamic clock-gating enable field |
| suspend_en | output | 1 | Suspend enable field |
| unit_present | output | 32 | Unit-presence contribution from this block |

## Verification
The bench targets the interactions that are easy to get wrong. One is an exception in the same cycle as a halting write: a design that gives the write priority would halt a core that is already heading into a handler. Another is a wrong-index write carrying the doze bit: loose decode would halt the core or corrupt the register. The bench also checks `resume_pc` at the top of the address space, where a wrong adder width would fail to wrap to 0. It checks that a non-halting write leaves `resume_pc` untouched, since a design that updated it every time would lose the real return address. Finally, it holds the core halted with no wake source to catch a halt that releases on its own, and releases it once from each wake source.

// File: rtl/pmr_pkg.sv
package pmr_pkg;
   localparam int SLOW_LSB  = 0;
   localparam int SLOW_W    = 4;
   localparam int DOZE_BIT  = 4;
   localparam int SLEEP_BIT = 5;
   localparam int CG_BIT    = 6;
   localparam int SUSP_BIT  = 7;
   localparam int FIELD_TOP = 7;
   localparam int GRP_SHIFT = 11;

   function automatic int spr_index(input int grp, input int num);
      return (grp << GRP_SHIFT) + num;
   endfunction
endpackage

// File: rtl/pmr_decode.sv
module pmr_decode #(
   parameter int ADDR_W = 16,
   parameter int GROUP  = 8,
   parameter int NUMBER = 0
) (
   input  logic [ADDR_W-1:0] spr_addr,
   output logic              hit
);
   localparam int          IDX     = pmr_pkg::spr_index(GROUP, NUMBER);
   localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(IDX);

   if (IDX >= (1 << ADDR_W)) begin : g_bad_idx
      $error("SPR index does not fit in ADDR_W");
   end

   assign hit = (spr_addr == MY_ADDR);
endmodule

// File: rtl/pmr_reg.sv
module pmr_reg #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   input  logic              exc,
   output logic [DATA_W-1:0] q
);
   import pmr_pkg::*;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= '0;
      end else begin
         if (wr_en) q <= wdata;
         if (exc) begin
            q[DOZE_BIT]  <= 1'b0;
            q[SLEEP_BIT] <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/pmr_halt.sv
module pmr_halt #(
   parameter int PC_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            set_req,
   input  logic            wake,
   input  logic            exc,
   input  logic [PC_W-1:0] pc,
   output logic            halt,
   output logic [PC_W-1:0] resume_pc
);
   localparam logic [PC_W-1:0] INSN_BYTES = PC_W'(4);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         halt      <= 1'b0;
         resume_pc <= '0;
      end else begin
         if (exc) begin
            halt <= 1'b0;
         end else if (set_req) begin
            halt      <= 1'b1;
            resume_pc <= pc + INSN_BYTES;
         end else if (halt && wake) begin
            halt <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/pwr_ctl_spr.sv
module pwr_ctl_spr #(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 32,
   parameter int PC_W        = 32,
   parameter int GROUP       = 8,
   parameter int NUMBER      = 0,
   parameter int UPR_W       = 32,
   parameter int PRES_BIT    = 9,
   parameter bit GATE_RDATA  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] spr_addr,
   input  logic              spr_wr,
   input  logic [DATA_W-1:0] spr_wdata,
   output logic [DATA_W-1:0] spr_rdata,
   input  logic [PC_W-1:0]   insn_pc,
   input  logic              exc_entry,
   input  logic              irq_pend,
   input  logic              tick_evt,
   output logic              halt,
   output logic [PC_W-1:0]   resume_pc,
   output logic [3:0]        slow_div,
   output logic              clkgate_en,
   output logic              suspend_en,
   output logic [UPR_W-1:0]  unit_present
);
   import pmr_pkg::*;

   if (DATA_W <= FIELD_TOP) begin : g_bad_data_w
      $error("DATA_W must hold the control fields");
   end
   if (PRES_BIT >= UPR_W) begin : g_bad_pres
      $error("PRES_BIT outside presence vector");
   end

   logic              addr_hit;
   logic              wr_hit;
   logic              halt_req;
   logic [DATA_W-1:0] pm_q;

   pmr_decode #(.ADDR_W(ADDR_W), .GROUP(GROUP), .NUMBER(NUMBER)) u_dec (
      .spr_addr (spr_addr),
      .hit      (addr_hit)
   );

   assign wr_hit   = spr_wr && addr_hit;
   assign halt_req = wr_hit && (spr_wdata[DOZE_BIT] || spr_wdata[SLEEP_BIT]);

   pmr_reg #(.DATA_W(DATA_W)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_hit),
      .wdata (spr_wdata),
      .exc   (exc_entry),
      .q     (pm_q)
   );

   pmr_halt #(.PC_W(PC_W)) u_halt (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_req   (halt_req),
      .wake      (irq_pend || tick_evt),
      .exc       (exc_entry),
      .pc        (insn_pc),
      .halt      (halt),
      .resume_pc (resume_pc)
   );

   if (GATE_RDATA) begin : g_rd_gated
      assign spr_rdata = addr_hit ? pm_q : '0;
   end else begin : g_rd_open
      assign spr_rdata = pm_q;
   end

   assign slow_div     = pm_q[SLOW_LSB +: SLOW_W];
   assign clkgate_en   = pm_q[CG_BIT];
   assign suspend_en   = pm_q[SUSP_BIT];
   assign unit_present = UPR_W'(1) << PRES_BIT;
endmodule

// File: rtl/pmr_chk.sv
module pmr_chk #(
   parameter int DATA_W = 32,
   parameter int PC_W   = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_hit,
   input logic [DATA_W-1:0] spr_wdata,
   input logic [PC_W-1:0]   insn_pc,
   input logic              exc_entry,
   input logic              irq_pend,
   input logic              tick_evt,
   input logic              halt,
   input logic [PC_W-1:0]   resume_pc,
   input logic [DATA_W-1:0] pm_q
);
   logic halting_wr;
   assign halting_wr = wr_hit && (spr_wdata[4] || spr_wdata[5]) && !exc_entry;

   AST_HALT_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      halting_wr |=> halt); // R4
   AST_RESUME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      halting_wr |=> resume_pc == $past(insn_pc) + PC_W'(4)); // R5
   AST_RESUME_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !halting_wr |=> $stable(resume_pc)); // R5
   AST_EXC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      exc_entry |=> (pm_q[5:4] == 2'b00) && !halt); // R7
   AST_WAKE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (halt && (irq_pend || tick_evt) && !wr_hit) |=> !halt); // R8
   AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (halt && !irq_pend && !tick_evt && !exc_entry) |=> halt); // R8
   AST_NO_STRAY_WR: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_hit && !exc_entry) |=> $stable(pm_q)); // R2
endmodule

bind pwr_ctl_spr pmr_chk #(.DATA_W(DATA_W), .PC_W(PC_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_hit    (wr_hit),
   .spr_wdata (spr_wdata),
   .insn_pc   (insn_pc),
   .exc_entry (exc_entry),
   .irq_pend  (irq_pend),
   .tick_evt  (tick_evt),
   .halt      (halt),
   .resume_pc (resume_pc),
   .pm_q      (pm_q)
);

// File: tb/sim_pwr_ctl_spr.sv
module sim_pwr_ctl_spr;
   localparam logic [15:0] PM_IDX = 16'h4000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] spr_addr = '0;
   logic        spr_wr = 1'b0;
   logic [31:0] spr_wdata = '0;
   logic [31:0] spr_rdata;
   logic [31:0] insn_pc = '0;
   logic        exc_entry = 1'b0;
   logic        irq_pend = 1'b0;
   logic        tick_evt = 1'b0;
   logic        halt;
   logic [31:0] resume_pc;
   logic [3:0]  slow_div;
   logic        clkgate_en;
   logic        suspend_en;
   logic [31:0] unit_present;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   pwr_ctl_spr u0 (
      .clk(clk), .rst_n(rst_n), .spr_addr(spr_addr), .spr_wr(spr_wr),
      .spr_wdata(spr_wdata), .spr_rdata(spr_rdata), .insn_pc(insn_pc),
      .exc_entry(exc_entry), .irq_pend(irq_pend), .tick_evt(tick_evt),
      .halt(halt), .resume_pc(resume_pc), .slow_div(slow_div),
      .clkgate_en(clkgate_en), .suspend_en(suspend_en),
      .unit_present(unit_present)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic spr_write(input logic [15:0] a, input logic [31:0] d,
                            input logic [31:0] pc, input logic exc);
      @(negedge clk);
      spr_addr = a; spr_wdata = d; insn_pc = pc; spr_wr = 1'b1; exc_entry = exc;
      @(negedge clk);
      spr_wr = 1'b0; exc_entry = 1'b0;
   endtask

   task automatic spr_read(input logic [15:0] a, output logic [31:0] d);
      @(negedge clk);
      spr_addr = a;
      #1 d = spr_rdata;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      chk("R1 halt", {31'b0, halt}, 32'h0);
      spr_read(PM_IDX, d);
      chk("R1 read", d, 32'h0);
      chk("R9 presence", unit_present, 32'h0000_0200);
   endtask

   task automatic t_decode();
      logic [31:0] d;
      spr_write(16'h4001, 32'h0000_0030, 32'h100, 1'b0);
      chk("R2 no halt on miss", {31'b0, halt}, 32'h0);
      spr_read(PM_IDX, d);
      chk("R2 reg untouched", d, 32'h0);
      spr_write(PM_IDX, 32'h0000_0003, 32'h200, 1'b0);
      spr_read(16'h0000, d);
      chk("R2 miss read zero", d, 32'h0);
   endtask

   task automatic t_readback();
      logic [31:0] d;
      spr_write(PM_IDX, 32'hA5A5_0F0F, 32'h300, 1'b0);
      spr_read(PM_IDX, d);
      chk("R3 full value", d, 32'hA5A5_0F0F);
      chk("R6 no halt", {31'b0, halt}, 32'h0);
      chk("R5 resume untouched", resume_pc, 32'h0);
      chk("R10 slow_div", {28'b0, slow_div}, 32'hF);
      spr_write(PM_IDX, 32'h0000_00C3, 32'h304, 1'b0);
      chk("R10 fields", {28'b0, slow_div, clkgate_en, suspend_en}, 32'h0000_000F);
   endtask

   task automatic t_doze_irq();
      spr_write(PM_IDX, 32'h0000_0010, 32'h0000_1000, 1'b0);
      chk("R4 doze halts", {31'b0, halt}, 32'h1);
      chk("R5 resume pc", resume_pc, 32'h0000_1004);
      idle(3);
      chk("R8 hold without wake", {31'b0, halt}, 32'h1);
      irq_pend = 1'b1;
      @(negedge clk);
      irq_pend = 1'b0;
      chk("R8 irq wakes", {31'b0, halt}, 32'h0);
   endtask

   task automatic t_sleep_tick();
      spr_write(PM_IDX, 32'h0000_0020, 32'hFFFF_FFFC, 1'b0);
      chk("R4 sleep halts", {31'b0, halt}, 32'h1);
      chk("R5 resume wraps", resume_pc, 32'h0000_0000);
      spr_write(16'h4002, 32'h0, 32'h500, 1'b0);
      chk("R5 resume kept", resume_pc, 32'h0000_0000);
      tick_evt = 1'b1;
      @(negedge clk);
      tick_evt = 1'b0;
      chk("R8 tick wakes", {31'b0, halt}, 32'h0);
   endtask

   task automatic t_exception();
      logic [31:0] d;
      spr_write(PM_IDX, 32'h0000_00F7, 32'h0000_2000, 1'b0);
      chk("R4 both bits halt", {31'b0, halt}, 32'h1);
      @(negedge clk);
      exc_entry = 1'b1;
      @(negedge clk);
      exc_entry = 1'b0;
      chk("R7 exc ends halt", {31'b0, halt}, 32'h0);
      spr_read(PM_IDX, d);
      chk("R7 bits cleared", d, 32'h0000_00C7);
      spr_write(PM_IDX, 32'h0000_0130, 32'h0000_3000, 1'b1);
      chk("R7 same-cycle no halt", {31'b0, halt}, 32'h0);
      spr_read(PM_IDX, d);
      chk("R7 same-cycle value", d, 32'h0000_0100);
      chk("R5 resume not taken", resume_pc, 32'h0000_2004);
   endtask

   initial begin
      #(4 * 20000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      idle(3);
      @(negedge clk) rst_n = 1'b1;
      t_reset();
      t_decode();
      t_readback();
      t_doze_irq();
      t_sleep_tick();
      t_exception();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule